// File: doc/BRIEF.md
# Infrared Carrier Modulation Output Stage

This block builds the drive signal for an infrared remote-control LED. A carrier timer produces a fast square wave whose period and high time are both programmable, so duty cycles such as one third or one half are available. A slower envelope timer, advanced by its own prescaled tick, produces on/off bursts of programmable length. The carrier is gated by an envelope that can come from that timer or from either of two serial transmit-data lines. The gated result can be inverted before it leaves the block on a single registered output.

Software sets the block up through a small write-only register port. A control word holds the enable, the output inversion bit and a two-bit envelope source field. Five further words hold the staged timer settings. New timer settings wait in staging registers until the running timer wraps, so a burst or carrier cycle is never cut short. While the block is disabled, both timers sit at zero and the output rests at its idle level.

Top module: `ir_mod_top`

## Requirements
- R1: The carrier count runs 0..CPER and wraps, giving a period of CPER+1 clocks; the carrier is high while the count is below CCMP.
- R2: The envelope prescaler gives one tick every PRE+1 clocks; the envelope count advances per tick over 0..EPER, and the envelope is high while that count is below ECMP.
- R3: Control bits [3:2] select the envelope: 0 = envelope timer, 1 = serial line A, 2 = serial line B, 3 = forced low.
- R4: When the block is enabled, the output equals carrier AND selected envelope, registered once: it shows the values of the previous clock.
- R5: Control bit 1 inverts the output when set.
- R6: While control bit 0 (enable) is clear, the output equals the inversion bit and both timers hold at zero.
- R7: A written timer setting takes effect when its timer wraps (carrier: count wraps; envelope: envelope count wraps on a tick), or at once while the block is disabled.
- R8: The register word addresses are: 0 control, 1 CPER, 2 CCMP, 3 PRE, 4 EPER, 5 ECMP. Writes to addresses 6 and 7 change nothing.
- R9: Synchronous reset clears every register, so after reset the block is disabled and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (3) | Register word address |
| cfg_wdata | input | DW (16) | Register write data |
| ser_tx_a | input | 1 | First serial transmit-data envelope source |
| ser_tx_b | input | 1 | Second serial transmit-data envelope source |
| ir_drive | output | 1 | Registered infrared drive output |

## Verification
The assertions check on every cycle that both counters stay within their active limits. They check that active settings change only at a wrap and that ignored addresses leave the registers untouched. They also check that a disabled block or the forced-low source yields exactly the idle level one clock later. Duty cycles, burst lengths, wrap timing of staged writes and the gating of serial data can only be shown by the bench. The bench counts high cycles over directed windows and compares the output every cycle against a model driven by random writes and random serial data.

// File: rtl/ir_pkg.sv
package ir_pkg;
  typedef enum logic [1:0] {
    ENV_TIMER = 2'd0,
    ENV_SER_A = 2'd1,
    ENV_SER_B = 2'd2,
    ENV_OFF   = 2'd3
  } env_src_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CPER = 1;
  localparam int unsigned ADDR_CCMP = 2;
  localparam int unsigned ADDR_PRE  = 3;
  localparam int unsigned ADDR_EPER = 4;
  localparam int unsigned ADDR_ECMP = 5;
  localparam int unsigned ADDR_LAST = 5;
endpackage

// File: rtl/ir_cfg_regs.sv
module ir_cfg_regs
  import ir_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned EW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          en,
  output logic          pol,
  output env_src_e      src,
  output logic [CW-1:0] cper,
  output logic [CW-1:0] ccmp,
  output logic [PW-1:0] pre,
  output logic [EW-1:0] eper,
  output logic [EW-1:0] ecmp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      pol  <= 1'b0;
      src  <= ENV_TIMER;
      cper <= '0;
      ccmp <= '0;
      pre  <= '0;
      eper <= '0;
      ecmp <= '0;
    end else if (cfg_we) begin
      case (int'(cfg_addr))
        ADDR_CTRL: begin
          en  <= cfg_wdata[0];
          pol <= cfg_wdata[1];
          src <= env_src_e'(cfg_wdata[3:2]);
        end
        ADDR_CPER: cper <= cfg_wdata[CW-1:0];
        ADDR_CCMP: ccmp <= cfg_wdata[CW-1:0];
        ADDR_PRE:  pre  <= cfg_wdata[PW-1:0];
        ADDR_EPER: eper <= cfg_wdata[EW-1:0];
        ADDR_ECMP: ecmp <= cfg_wdata[EW-1:0];
        default: ;
      endcase
    end
  end

  // R8: unmapped addresses leave every register untouched
  p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_addr) > ADDR_LAST) |=>
      ($stable(en) && $stable(pol) && $stable(src) && $stable(cper) &&
       $stable(ccmp) && $stable(pre) && $stable(eper) && $stable(ecmp)));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] per_stage,
  input  logic [CW-1:0] cmp_stage,
  output logic          carrier
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt;
  logic [CW-1:0] per_act;
  logic [CW-1:0] cmp_act;
  logic          wrap;

  assign wrap = (cnt == per_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_act <= '0;
      cmp_act <= '0;
    end else if (!en || wrap) begin
      cnt     <= '0;
      per_act <= per_stage;
      cmp_act <= cmp_stage;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  assign carrier = (cnt < cmp_act);

  // R1: count never exceeds the active period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_act);
  // R6: disabled carrier counter sits at zero
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
  // R7: active settings only move at a wrap
  p_hold_midcycle_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> ($stable(per_act) && $stable(cmp_act)));
endmodule

// File: rtl/ir_env_gen.sv
module ir_env_gen #(
  parameter int unsigned EW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] pre_stage,
  input  logic [EW-1:0] per_stage,
  input  logic [EW-1:0] cmp_stage,
  output logic          envelope
);
  localparam logic [PW-1:0] PONE = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [EW-1:0] EONE = {{(EW-1){1'b0}}, 1'b1};

  logic [PW-1:0] pcnt;
  logic [PW-1:0] pre_act;
  logic [EW-1:0] ecnt;
  logic [EW-1:0] per_act;
  logic [EW-1:0] cmp_act;
  logic          tick;
  logic          wrap;

  assign tick = (pcnt == pre_act);
  assign wrap = tick && (ecnt == per_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      ecnt    <= '0;
      pre_act <= '0;
      per_act <= '0;
      cmp_act <= '0;
    end else if (!en || wrap) begin
      pcnt    <= '0;
      ecnt    <= '0;
      pre_act <= pre_stage;
      per_act <= per_stage;
      cmp_act <= cmp_stage;
    end else if (tick) begin
      pcnt <= '0;
      ecnt <= ecnt + EONE;
    end else begin
      pcnt <= pcnt + PONE;
    end
  end

  assign envelope = (ecnt < cmp_act);

  // R2: both counters stay inside their active limits
  p_pcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    pcnt <= pre_act);
  p_ecnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ecnt <= per_act);
  // R2: envelope count moves only on a tick
  p_step_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(ecnt));
  // R7: envelope settings only move at an envelope wrap
  p_hold_midburst_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> ($stable(pre_act) && $stable(per_act) && $stable(cmp_act)));
endmodule

// File: rtl/ir_out_stage.sv
module ir_out_stage
  import ir_pkg::*;
#(
  parameter bit SER_SYNC = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     pol,
  input  env_src_e src,
  input  logic     carrier,
  input  logic     env_timer,
  input  logic     ser_a,
  input  logic     ser_b,
  output logic     drive
);
  logic ser_a_s;
  logic ser_b_s;
  logic env_sel;

  generate
    if (SER_SYNC) begin : g_ser_reg
      logic a_q;
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          a_q <= 1'b0;
          b_q <= 1'b0;
        end else begin
          a_q <= ser_a;
          b_q <= ser_b;
        end
      end
      assign ser_a_s = a_q;
      assign ser_b_s = b_q;
    end else begin : g_ser_direct
      assign ser_a_s = ser_a;
      assign ser_b_s = ser_b;
    end
  endgenerate

  always_comb begin
    case (src)
      ENV_TIMER: env_sel = env_timer;
      ENV_SER_A: env_sel = ser_a_s;
      ENV_SER_B: env_sel = ser_b_s;
      default:   env_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     drive <= 1'b0;
    else if (en) drive <= (carrier & env_sel) ^ pol;
    else         drive <= pol;
  end

  // R6: disabled output is the idle level one clock later
  p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> drive == $past(pol));
  // R3: the forced-low source never lets the carrier through
  p_src_off_r3: assert property (@(posedge clk) disable iff (rst)
    (en && src == ENV_OFF) |=> drive == $past(pol));
  // R4: a low carrier always gives the idle level
  p_carrier_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !carrier) |=> drive == $past(pol));
endmodule

// File: rtl/ir_mod_top.sv
module ir_mod_top
  import ir_pkg::*;
#(
  parameter int unsigned AW       = 3,
  parameter int unsigned DW       = 16,
  parameter int unsigned CW       = 16,
  parameter int unsigned EW       = 16,
  parameter int unsigned PW       = 16,
  parameter bit          SER_SYNC = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ser_tx_a,
  input  logic          ser_tx_b,
  output logic          ir_drive
);
  logic          en;
  logic          pol;
  env_src_e      src;
  logic [CW-1:0] cper;
  logic [CW-1:0] ccmp;
  logic [PW-1:0] pre;
  logic [EW-1:0] eper;
  logic [EW-1:0] ecmp;
  logic          carrier;
  logic          env_timer;

  ir_cfg_regs #(.AW(AW), .DW(DW), .CW(CW), .EW(EW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en(en), .pol(pol), .src(src),
    .cper(cper), .ccmp(ccmp), .pre(pre), .eper(eper), .ecmp(ecmp)
  );

  ir_carrier_gen #(.CW(CW)) u_carrier (
    .clk(clk), .rst(rst), .en(en), .per_stage(cper), .cmp_stage(ccmp),
    .carrier(carrier)
  );

  ir_env_gen #(.EW(EW), .PW(PW)) u_env (
    .clk(clk), .rst(rst), .en(en), .pre_stage(pre), .per_stage(eper),
    .cmp_stage(ecmp), .envelope(env_timer)
  );

  ir_out_stage #(.SER_SYNC(SER_SYNC)) u_out (
    .clk(clk), .rst(rst), .en(en), .pol(pol), .src(src),
    .carrier(carrier), .env_timer(env_timer), .ser_a(ser_tx_a),
    .ser_b(ser_tx_b), .drive(ir_drive)
  );

  // R9: the cycle after reset the output is low
  p_reset_low_r9: assert property (@(posedge clk)
    rst |=> !ir_drive);
endmodule

// File: tb/ir_mod_top_tb.sv
module ir_mod_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        ser_tx_a = 1'b0;
  logic        ser_tx_b = 1'b0;
  logic        ir_drive;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ir_mod_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ser_tx_a(ser_tx_a), .ser_tx_b(ser_tx_b),
    .ir_drive(ir_drive)
  );

  // ---------- reference model built from the requirements ----------
  logic        m_en, m_pol;
  logic [1:0]  m_src;
  logic [15:0] s_cper, s_ccmp, s_pre, s_eper, s_ecmp;
  logic [15:0] a_cper, a_ccmp, a_pre, a_eper, a_ecmp;
  logic [15:0] m_c, m_p, m_e;
  logic        m_out;

  function automatic logic f_env(input logic [1:0] s, input logic t,
                                 input logic a, input logic b);
    case (s)
      2'd0: return t;
      2'd1: return a;
      2'd2: return b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic f_drive(input logic en, input logic pol,
                                   input logic car, input logic env);
    if (!en) return pol;
    return (car && env) ? !pol : pol;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_pol <= 0; m_src <= 0;
      s_cper <= 0; s_ccmp <= 0; s_pre <= 0; s_eper <= 0; s_ecmp <= 0;
      a_cper <= 0; a_ccmp <= 0; a_pre <= 0; a_eper <= 0; a_ecmp <= 0;
      m_c <= 0; m_p <= 0; m_e <= 0; m_out <= 0;
    end else begin
      m_out <= f_drive(m_en, m_pol, m_c < a_ccmp,
                       f_env(m_src, m_e < a_ecmp, ser_tx_a, ser_tx_b));
      if (!m_en) begin
        m_c <= 0; m_p <= 0; m_e <= 0;
        a_cper <= s_cper; a_ccmp <= s_ccmp;
        a_pre <= s_pre; a_eper <= s_eper; a_ecmp <= s_ecmp;
      end else begin
        if (m_c == a_cper) begin
          m_c <= 0; a_cper <= s_cper; a_ccmp <= s_ccmp;
        end else m_c <= m_c + 16'd1;
        if (m_p == a_pre) begin
          m_p <= 0;
          if (m_e == a_eper) begin
            m_e <= 0; a_pre <= s_pre; a_eper <= s_eper; a_ecmp <= s_ecmp;
          end else m_e <= m_e + 16'd1;
        end else m_p <= m_p + 16'd1;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_en <= cfg_wdata[0]; m_pol <= cfg_wdata[1]; m_src <= cfg_wdata[3:2]; end
          3'd1: s_cper <= cfg_wdata;
          3'd2: s_ccmp <= cfg_wdata;
          3'd3: s_pre  <= cfg_wdata;
          3'd4: s_eper <= cfg_wdata;
          3'd5: s_ecmp <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------- per-cycle comparison ----------
  logic track = 1'b0;
  int   mism = 0;
  always @(negedge clk) if (track && !rst && ir_drive !== m_out) mism++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ir_drive) hi++;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int hi;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ir_drive == 1'b0, "R9 reset output", int'(ir_drive), 0);

    // R1 duty one third: period 6, high 2
    wr(1, 5); wr(2, 2); ser_tx_a = 1'b1;
    wr(0, 32'h5);                       // en, src=serial A
    repeat (8) @(negedge clk);
    count_high(60, hi);
    check(hi == 20, "R1 duty 1/3", hi, 20);

    // R7 staged write waits for wrap; duty one half
    wr(1, 7); wr(2, 4);
    repeat (10) @(negedge clk);
    count_high(64, hi);
    check(hi == 32, "R7/R1 duty 1/2 after wrap", hi, 32);

    // R5 inversion
    wr(0, 32'h7);
    repeat (10) @(negedge clk);
    count_high(64, hi);
    check(hi == 32, "R5 inverted duty", hi, 32);

    // R6 disabled: idle level equals inversion bit
    wr(0, 32'h2);
    repeat (3) @(negedge clk);
    count_high(20, hi);
    check(hi == 20, "R6 idle high with inversion", hi, 20);
    wr(0, 32'h0);
    repeat (2) @(negedge clk);
    count_high(20, hi);
    check(hi == 0, "R6 idle low", hi, 0);

    // R2 envelope timer: carrier always on, tick every 2, 2 of 5 ticks high
    wr(1, 0); wr(2, 1); wr(3, 1); wr(4, 4); wr(5, 2);
    wr(0, 32'h1);
    repeat (4) @(negedge clk);
    count_high(100, hi);
    check(hi == 40, "R2 envelope burst", hi, 40);

    // R3 serial B selected, B low then high
    ser_tx_b = 1'b0;
    wr(0, 32'h9);
    repeat (3) @(negedge clk);
    count_high(30, hi);
    check(hi == 0, "R3 serial B low", hi, 0);
    ser_tx_b = 1'b1;
    repeat (2) @(negedge clk);
    count_high(30, hi);
    check(hi == 30, "R3/R4 serial B high", hi, 30);

    // R3 forced-low source
    ser_tx_a = 1'b1;
    wr(0, 32'hD);
    repeat (3) @(negedge clk);
    count_high(40, hi);
    check(hi == 0, "R3 source 3 forced low", hi, 0);

    // R8 unmapped writes change nothing: output stays with serial B high
    wr(0, 32'h9);
    wr(6, 32'hFFFF); wr(7, 32'h0);
    repeat (2) @(negedge clk);
    count_high(30, hi);
    check(hi == 30, "R8 unmapped ignored", hi, 30);

    // R4/R7 lockstep: random writes and serial data against the model
    for (int it = 0; it < 40; it++) begin
      mism = 0;
      track = 1'b1;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        ser_tx_a = 1'($urandom);
        ser_tx_b = 1'($urandom);
        if (($urandom % 16) == 0) begin
          cfg_we = 1'b1;
          cfg_addr = 3'($urandom % 8);
          cfg_wdata = (cfg_addr == 3'd0) ? 16'($urandom % 16 | ((it % 5 == 0) ? 0 : 1))
                                         : 16'($urandom % 12);
        end else begin
          cfg_we = 1'b0;
        end
      end
      @(negedge clk);
      cfg_we = 1'b0;
      track = 1'b0;
      check(mism == 0, "R4/R7 lockstep random", mism, 0);
    end

    // R9 reset again mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ir_drive == 1'b0, "R9 reset after run", int'(ir_drive), 0);

    summary();
  end
endmodule